// File: doc/BRIEF.md
# Segmented Multi-Lane Sample Input Buffer

This block collects a frame of samples arriving eight per clock from an upstream correction stage and hands them to eight downstream two-tap filter lanes. While the write enable is high, the eight input samples of a clock go into consecutive locations of a 512-entry, 13-bit memory. The write pointer advances by eight on each such clock.

The memory is split into eight contiguous 64-entry segments, one per lane. Lane k starts streaming its segment one sample per clock once the write pointer has passed the first eight entries of that segment. The lanes therefore start at staggered times while the frame is still being written. A lane's first output cycle also carries a bypass enable and a bypass value of zero. The filter uses them in place of its first result, which would otherwise be corrupted by the filter's empty delay stage.

When the buffer is full, further writes are dropped. Once every lane has streamed its whole segment, the write pointer returns to zero and a new frame can be written.

Top module: `seg_input_buffer`

## Requirements
- R1: After reset, every lane's read enable and bypass enable are low and every lane data output is zero. The write pointer starts at zero.
- R2: On a clock with the write enable high and the buffer not full, input lane i is stored at address pointer+i and the pointer then advances by eight.
- R3: Lane k's first output appears on the clock after the write pointer reaches 8+64k, for k = 0 to 7. With writes on every clock starting at edge N, lane k's first output follows edge N+1+8k.
- R4: Lane k outputs addresses 64k through 64k+63 in ascending order, one per clock on 64 consecutive clocks with its read enable high. The read enable then goes low.
- R5: A lane's bypass enable is high on exactly the first of its 64 output cycles, and the bypass value on that cycle is zero.
- R6: The write pointer never exceeds 512. A write enable presented while the buffer is full stores nothing, so the data still streamed out of the segments is unchanged.
- R7: Once the buffer is full and all eight lanes have finished their segments, the pointer returns to zero on the next clock. The following frame is then written from address 0 and streamed again.
- R8: On a clock with the write enable low, nothing is written and the pointer holds. Lane start times follow the pointer, so with writes on every other clock, lane 1 starts 18 clocks after the first write edge's preceding cycle.
- R9: Output data are registered: the sample for a read pointer appears one clock after that pointer is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write enable for the eight input samples |
| inSamples | input | 8x13 | Eight input samples, lane i to address pointer+i |
| laneData | output | 8x13 | Registered read data per lane |
| laneRdEn | output | 8 | Lane output valid (read enable to the filter) |
| bypassEn | output | 8 | High on the first output cycle of each lane |
| bypassVal | output | 8x13 | Replacement value for the filter's first result (zero) |

## Verification
The embedded properties check on every cycle that:
- the write pointer stays within the buffer, moves only by eight or back to zero, and holds while full until all lanes finish;
- lane read pointers stay within their segment;
- the bypass enable coincides with the rising read enable and never lasts two cycles.

The scenarios show what those properties cannot:
- the data values on each lane, which are compared against a port-level model of the memory;
- the exact staggered start clocks, for both continuous and every-other-clock writing;
- that writes presented while full leave the streamed data intact;
- that a second frame starts again from address 0.

// File: rtl/sib_pkg.sv
package sib_pkg;
  localparam int LANES    = 8;
  localparam int DEPTH    = 512;
  localparam int SAMPLE_W = 13;

  // strobes from the control to the datapath
  typedef struct packed {
    logic             wr;
    logic [LANES-1:0] rd;
    logic [LANES-1:0] first;
  } sib_stb_t;
endpackage

// File: rtl/sib_ctrl.sv
module sib_ctrl
  import sib_pkg::*;
#(
  parameter int DEPTH_P = DEPTH,
  localparam int SEG    = DEPTH_P / LANES,
  localparam int ADDR_W = $clog2(DEPTH_P),
  localparam int PTR_W  = ADDR_W + 1,
  localparam int SEG_W  = $clog2(SEG)
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic                           wrEn,
  output sib_stb_t                       stb,
  output logic [ADDR_W-1:0]              wrAddr,
  output logic [LANES-1:0][ADDR_W-1:0]   rdAddr
);
  logic [PTR_W-1:0] wrPtr;
  logic [LANES-1:0] laneAct, laneDone, laneStart;
  logic [SEG_W-1:0] rdPtr [LANES];
  logic             full, allDone, rearm, wrGo;

  assign full    = (wrPtr == PTR_W'(DEPTH_P));
  assign allDone = &laneDone;
  assign rearm   = full && allDone;
  assign wrGo    = wrEn && !full;
  assign wrAddr  = wrPtr[ADDR_W-1:0];

  always_comb begin
    stb.wr    = wrGo;
    stb.rd    = laneStart | laneAct;
    stb.first = laneStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      wrPtr <= '0;
    else if (wrGo)  wrPtr <= wrPtr + PTR_W'(LANES);
    else if (rearm) wrPtr <= '0;
  end

  p_ptr_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    wrPtr <= PTR_W'(DEPTH_P));
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (wrPtr == $past(wrPtr) || wrPtr == $past(wrPtr) + PTR_W'(LANES) || wrPtr == '0));
  p_full_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (full && !allDone) |=> full);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    localparam int THRESH = LANES + k * SEG;
    localparam logic [ADDR_W-1:0] BASE = ADDR_W'(k * SEG);

    assign laneStart[k] = (wrPtr == PTR_W'(THRESH)) && !laneAct[k] && !laneDone[k];
    assign rdAddr[k]    = BASE + (laneAct[k] ? ADDR_W'(rdPtr[k]) : '0);

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneAct[k]  <= 1'b0;
        laneDone[k] <= 1'b0;
        rdPtr[k]    <= '0;
      end else if (rearm) begin
        laneDone[k] <= 1'b0;
      end else if (laneStart[k]) begin
        laneAct[k] <= 1'b1;
        rdPtr[k]   <= SEG_W'(1);
      end else if (laneAct[k]) begin
        if (rdPtr[k] == SEG_W'(SEG - 1)) begin
          laneAct[k]  <= 1'b0;
          laneDone[k] <= 1'b1;
          rdPtr[k]    <= '0;
        end else begin
          rdPtr[k] <= rdPtr[k] + 1'b1;
        end
      end
    end

    p_act_not_done_r4: assert property (@(posedge clk) disable iff (!rstN)
      !(laneAct[k] && laneDone[k]));
    p_start_thresh_r3: assert property (@(posedge clk) disable iff (!rstN)
      $rose(laneAct[k]) |-> $past(wrPtr) == PTR_W'(THRESH));
  end
endmodule

// File: rtl/sib_dpath.sv
module sib_dpath
  import sib_pkg::*;
#(
  parameter int DEPTH_P  = DEPTH,
  parameter int WIDTH_P  = SAMPLE_W,
  localparam int ADDR_W  = $clog2(DEPTH_P)
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  sib_stb_t                          stb,
  input  logic [ADDR_W-1:0]                 wrAddr,
  input  logic [LANES-1:0][ADDR_W-1:0]      rdAddr,
  input  logic [LANES-1:0][WIDTH_P-1:0]     inSamples,
  output logic [LANES-1:0][WIDTH_P-1:0]     laneData,
  output logic [LANES-1:0]                  laneRdEn,
  output logic [LANES-1:0]                  bypassEn,
  output logic [LANES-1:0][WIDTH_P-1:0]     bypassVal
);
  logic [WIDTH_P-1:0] mem [DEPTH_P];

  always_ff @(posedge clk) begin
    if (stb.wr) begin
      for (int i = 0; i < LANES; i++) mem[wrAddr + ADDR_W'(i)] <= inSamples[i];
    end
  end

  assign bypassVal = '0;

  for (genvar k = 0; k < LANES; k++) begin : g_rd
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        laneData[k] <= '0;
        laneRdEn[k] <= 1'b0;
        bypassEn[k] <= 1'b0;
      end else begin
        laneRdEn[k] <= stb.rd[k];
        bypassEn[k] <= stb.first[k];
        if (stb.rd[k]) laneData[k] <= mem[rdAddr[k]];
      end
    end

    p_rise_bypass_r5: assert property (@(posedge clk) disable iff (!rstN)
      $rose(laneRdEn[k]) |-> bypassEn[k]);
    p_bypass_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
      bypassEn[k] |-> laneRdEn[k]);
    p_bypass_once_r5: assert property (@(posedge clk) disable iff (!rstN)
      bypassEn[k] |=> !bypassEn[k]);
  end
endmodule

// File: rtl/seg_input_buffer.sv
module seg_input_buffer
  import sib_pkg::*;
(
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               wrEn,
  input  logic [LANES-1:0][SAMPLE_W-1:0]     inSamples,
  output logic [LANES-1:0][SAMPLE_W-1:0]     laneData,
  output logic [LANES-1:0]                   laneRdEn,
  output logic [LANES-1:0]                   bypassEn,
  output logic [LANES-1:0][SAMPLE_W-1:0]     bypassVal
);
  localparam int ADDR_W = $clog2(DEPTH);

  sib_stb_t                      stb;
  logic [ADDR_W-1:0]             wrAddr;
  logic [LANES-1:0][ADDR_W-1:0]  rdAddr;

  sib_ctrl #(.DEPTH_P(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn),
    .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  sib_dpath #(.DEPTH_P(DEPTH), .WIDTH_P(SAMPLE_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .inSamples(inSamples), .laneData(laneData), .laneRdEn(laneRdEn),
    .bypassEn(bypassEn), .bypassVal(bypassVal)
  );
endmodule

// File: tb/tb_seg_input_buffer.sv
module tb_seg_input_buffer;
  import sib_pkg::*;
  localparam int SEG = DEPTH / LANES;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0;
  logic [LANES-1:0][SAMPLE_W-1:0] inSamples = '0;
  logic [LANES-1:0][SAMPLE_W-1:0] laneData, bypassVal;
  logic [LANES-1:0] laneRdEn, bypassEn;

  int compared = 0, mismatched = 0, cyc = 0;
  bit monOn = 1'b0;
  int firstSeen [LANES];

  seg_input_buffer dut (.*);

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  task automatic chk(string req, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  // port-level reference model built from the requirements
  logic [SAMPLE_W-1:0] mMem [DEPTH];
  int mPtr;
  bit mAct [LANES];
  bit mDone [LANES];
  int mCnt [LANES];
  bit mEn [LANES];
  bit mFirst [LANES];
  int mData [LANES];

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mPtr = 0;
      for (int k = 0; k < LANES; k++) begin
        mAct[k] = 0; mDone[k] = 0; mCnt[k] = 0; mEn[k] = 0; mFirst[k] = 0; mData[k] = 0;
      end
    end else begin
      bit allD, wasFull;
      allD = 1;
      for (int k = 0; k < LANES; k++) allD &= mDone[k];
      wasFull = (mPtr == DEPTH);
      for (int k = 0; k < LANES; k++) begin
        bit st;
        st = (mPtr == LANES + k * SEG) && !mAct[k] && !mDone[k];
        mEn[k] = st || mAct[k];
        mFirst[k] = st;
        if (st) begin
          mData[k] = mMem[k * SEG]; mAct[k] = 1; mCnt[k] = 1;
        end else if (mAct[k]) begin
          mData[k] = mMem[k * SEG + mCnt[k]];
          if (mCnt[k] == SEG - 1) begin mAct[k] = 0; mDone[k] = 1; mCnt[k] = 0; end
          else mCnt[k]++;
        end
      end
      if (wrEn && !wasFull) begin
        for (int i = 0; i < LANES; i++) mMem[mPtr + i] = inSamples[i];
        mPtr += LANES;
      end else if (wasFull && allD) begin
        mPtr = 0;
        for (int k = 0; k < LANES; k++) mDone[k] = 0;
      end
    end
  end

  // continuous comparison away from the active edge (R2, R4, R5, R6, R9)
  always @(negedge clk) begin
    if (rstN && monOn) begin
      for (int k = 0; k < LANES; k++) begin
        chk("R4", $sformatf("lane%0d rdEn", k), int'(laneRdEn[k]), int'(mEn[k]));
        chk("R5", $sformatf("lane%0d bypassEn", k), int'(bypassEn[k]), int'(mFirst[k]));
        if (mEn[k]) chk("R2/R9", $sformatf("lane%0d data", k), int'(laneData[k]), mData[k]);
        if (mFirst[k]) chk("R5", $sformatf("lane%0d bypassVal", k), int'(bypassVal[k]), 0);
      end
    end
    for (int k = 0; k < LANES; k++)
      if (rstN && bypassEn[k] && firstSeen[k] < 0) firstSeen[k] = cyc;
  end

  function automatic logic [SAMPLE_W-1:0] sval(int frame, int c, int i);
    return SAMPLE_W'((frame * 1237 + c * 8 + i) * 37 + 5);
  endfunction

  task automatic clearSeen();
    for (int k = 0; k < LANES; k++) firstSeen[k] = -1;
  endtask

  task automatic testReset();
    chk("R1", "rdEn after reset", int'(laneRdEn), 0);
    chk("R1", "bypassEn after reset", int'(bypassEn), 0);
    chk("R1", "data after reset", int'(laneData[0]) + int'(laneData[7]), 0);
  endtask

  // contiguous frame, optionally followed by writes while full
  task automatic testFrame(int frame, int extra, string req);
    int startCyc;
    clearSeen();
    startCyc = cyc;
    for (int c = 0; c < SEG + extra; c++) begin
      wrEn = 1'b1;
      for (int i = 0; i < LANES; i++) inSamples[i] = sval(frame, c, i);
      @(negedge clk);
    end
    wrEn = 1'b0;
    while (cyc < startCyc + 140) @(negedge clk);
    for (int k = 0; k < LANES; k++)
      chk(req, $sformatf("R3 lane%0d start cycle", k), firstSeen[k] - startCyc, 2 + 8 * k);
  endtask

  // writes on every other clock (R8)
  task automatic testHalfRate(int frame);
    int startCyc;
    clearSeen();
    startCyc = cyc;
    for (int c = 0; c < 2 * SEG; c++) begin
      wrEn = (c % 2 == 0);
      for (int i = 0; i < LANES; i++) inSamples[i] = sval(frame, c, i);
      @(negedge clk);
    end
    wrEn = 1'b0;
    while (cyc < startCyc + 200) @(negedge clk);
    chk("R8", "lane0 start cycle", firstSeen[0] - startCyc, 2);
    chk("R8", "lane1 start cycle", firstSeen[1] - startCyc, 18);
    chk("R8", "lane7 start cycle", firstSeen[7] - startCyc, 114);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    mismatched++;
    compared++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    clearSeen();
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    monOn = 1'b1;
    testFrame(1, 0, "R3");
    testFrame(2, 40, "R6");
    testFrame(3, 0, "R7");
    testHalfRate(4);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule